// File: doc/BRIEF.md
# Low-Power Seconds Counter with Alarm

This peripheral keeps wall-clock time in a free-running counter that advances on each rising edge of a slow (nominally 32 kHz) low-power clock. The counter is split into a whole-seconds word and a fractional field. A seconds-resolution comparator raises an alarm flag, and one interrupt line is formed from the status flags that software has enabled. The block is accessed through a simple 32-bit register port that runs on the system bus clock.

The slow clock is sampled into the bus clock domain by a synchronizer, and every state update is aligned to a detected slow-clock edge. Writes to the counter, alarm, control and status registers are therefore staged. A staged write takes effect on the next slow edge, and a write-complete flag reports when that has happened. Only one write can be in flight at a time. A second write that arrives while one is staged is refused and flagged as an error. Writes to the interrupt-enable register skip this path and land at once.

After reset the time is marked not valid. The counter keeps still until software does three things: clears the not-valid flag, loads the seconds word at least once, and sets the run bit in control.

Top module: `rtc_lp_counter`

## Requirements
- R1: After reset, seconds and fraction read 0, alarm seconds reads 0xFFFFFFFF, control and interrupt-enable read 0, status reads 0x203 (bits 9, 1 and 0 set), and `irq` is low.
- R2: The time value is {seconds at 0x00, fraction at 0x04 in bits [FRAC_W-1:0]}. While running, the fraction steps by one per slow-clock rising edge and carries into seconds when it wraps.
- R3: The counter holds its value unless all three conditions are met: control bit 3 is set, the seconds word has been written since reset, and status bit 1 (not-valid) is clear.
- R4: A write to offsets 0x00, 0x04, 0x08, 0x0C, 0x10 or 0x14 is held until the next detected slow-clock edge and then applied. While it is held, status bit 10 (busy) reads 1 and bit 9 (ready) reads 0.
- R5: Status bit 8 (write complete) is set when a held write is applied. A status read returns the flag and then clears it.
- R6: A slow-path write that arrives while another is held is discarded and sets status bit 7 (write error).
- R7: A write to offset 0x18 updates interrupt-enable in the next cycle, keeping only bits 9, 8, 7 and 4. It never sets status bit 8.
- R8: Writing 1 to status bit 7, 4, 1 or 0 clears that flag once the write is applied. A 0 in any bit leaves that flag unchanged.
- R9: Status bit 4 (alarm) is set whenever the seconds word equals alarm seconds (0x08) while not-valid is clear.
- R10: `irq` is registered. It is high one cycle after any of status bits 9, 8, 7 or 4 is set together with the same bit of interrupt-enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| lp_clk | input | 1 | Slow low-power clock, sampled asynchronously |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with FRAC_W=4 and SYNC_STAGES=2, and drives a slow clock with one eighth of the bus rate. At that setting one second lasts 128 bus cycles. Fraction wrap, carries into seconds and alarm hits all happen within a few hundred cycles, and the full 15-bit default would put them out of reach. The eight-cycle gap between slow edges also leaves a wide window in which a held write can be caught as busy and a back-to-back write is sure to be refused.

// File: rtl/rtc_lp_pkg.sv
package rtc_lp_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_SEC      = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_FRAC     = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_ALM_SEC  = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_ALM_FRAC = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CTRL     = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_STAT     = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_IEN      = 5'h18;

  localparam int unsigned ST_SVF = 0;
  localparam int unsigned ST_NVF = 1;
  localparam int unsigned ST_CAF = 4;
  localparam int unsigned ST_WEF = 7;
  localparam int unsigned ST_WCF = 8;
  localparam int unsigned ST_WNF = 9;
  localparam int unsigned ST_WBF = 10;
  localparam int unsigned CTL_RUN = 3;

  localparam logic [DATA_W-1:0] IEN_MASK = 32'h0000_0390;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/rtc_tick_sync.sv
module rtc_tick_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic tick
);
  localparam int unsigned MSB = STAGES - 1;

  logic [MSB:0] sr;
  logic         last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr   <= '0;
      last <= 1'b0;
      tick <= 1'b0;
    end else begin
      sr   <= {sr[MSB-1:0], async_in};
      last <= sr[MSB];
      tick <= sr[MSB] & ~last;
    end
  end
endmodule

// File: rtl/rtc_wr_stage.sv
module rtc_wr_stage
  import rtc_lp_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    req_valid,
  input  wr_req_t req,
  input  logic    tick,
  output logic    pending,
  output wr_req_t held,
  output logic    apply,
  output logic    reject
);
  assign apply  = pending & tick;
  assign reject = req_valid & pending;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending <= 1'b0;
      held    <= '0;
    end else if (pending) begin
      if (tick) pending <= 1'b0;
    end else if (req_valid) begin
      pending <= 1'b1;
      held    <= req;
    end
  end

  // R6: a refused write leaves the staged request untouched
  a_r6_keep_staged: assert property (@(posedge clk) disable iff (rst)
    (pending && req_valid) |=> (held == $past(held)));

  // R4: a staged write waits for a slow edge
  a_r4_wait_edge: assert property (@(posedge clk) disable iff (rst)
    (pending && !tick) |=> pending);
endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned FRAC_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              run_en,
  input  logic              ld_sec,
  input  logic              ld_frac,
  input  logic [SEC_W-1:0]  ld_data,
  output logic [SEC_W-1:0]  sec,
  output logic [FRAC_W-1:0] frac
);
  localparam int unsigned CNT_W = SEC_W + FRAC_W;

  logic [CNT_W-1:0] next_cnt;
  assign next_cnt = {sec, frac} + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec  <= '0;
      frac <= '0;
    end else if (ld_sec) begin
      sec <= ld_data;
    end else if (ld_frac) begin
      frac <= ld_data[FRAC_W-1:0];
    end else if (tick && run_en) begin
      {sec, frac} <= next_cnt;
    end
  end

  // R3: no movement while stopped and not loaded
  a_r3_held: assert property (@(posedge clk) disable iff (rst)
    (!run_en && !ld_sec && !ld_frac) |=> ($stable(sec) && $stable(frac)));
endmodule

// File: rtl/rtc_lp_counter.sv
module rtc_lp_counter
  import rtc_lp_pkg::*;
#(
  parameter int unsigned FRAC_W      = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lp_clk,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              tick, pend, apply, reject, slow_hit, wr_slow;
  wr_req_t           held;
  logic [DATA_W-1:0] sec, alm_sec, ctrl, ien, status;
  logic [FRAC_W-1:0] frac, alm_frac;
  logic              svf, nvf, caf, wef, wcf, sec_written;
  logic              ld_sec, ld_frac, run_en, alarm_hit, rd_stat;

  rtc_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_in(lp_clk), .tick(tick));

  always_comb begin
    unique case (bus_addr)
      OFS_SEC, OFS_FRAC, OFS_ALM_SEC, OFS_ALM_FRAC, OFS_CTRL, OFS_STAT: slow_hit = 1'b1;
      default: slow_hit = 1'b0;
    endcase
  end
  assign wr_slow = bus_wr & slow_hit;

  rtc_wr_stage u_stage (
    .clk(clk), .rst(rst), .req_valid(wr_slow),
    .req('{addr: bus_addr, data: bus_wdata}), .tick(tick),
    .pending(pend), .held(held), .apply(apply), .reject(reject));

  assign ld_sec  = apply && (held.addr == OFS_SEC);
  assign ld_frac = apply && (held.addr == OFS_FRAC);
  assign run_en  = ctrl[CTL_RUN] & sec_written & ~nvf;

  rtc_time_core #(.SEC_W(DATA_W), .FRAC_W(FRAC_W)) u_core (
    .clk(clk), .rst(rst), .tick(tick), .run_en(run_en),
    .ld_sec(ld_sec), .ld_frac(ld_frac), .ld_data(held.data),
    .sec(sec), .frac(frac));

  assign alarm_hit = (sec == alm_sec) & ~nvf;
  assign rd_stat   = bus_rd && (bus_addr == OFS_STAT);

  always_comb begin
    status         = '0;
    status[ST_SVF] = svf;
    status[ST_NVF] = nvf;
    status[ST_CAF] = caf;
    status[ST_WEF] = wef;
    status[ST_WCF] = wcf;
    status[ST_WNF] = ~pend;
    status[ST_WBF] = pend;
  end

  // configuration registers behind the slow path
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl        <= '0;
      alm_sec     <= '1;
      alm_frac    <= '0;
      sec_written <= 1'b0;
    end else if (apply) begin
      unique case (held.addr)
        OFS_CTRL:     ctrl        <= held.data;
        OFS_ALM_SEC:  alm_sec     <= held.data;
        OFS_ALM_FRAC: alm_frac    <= held.data[FRAC_W-1:0];
        OFS_SEC:      sec_written <= 1'b1;
        default: ;
      endcase
    end
  end

  // status flags: clears first, sets win
  always_ff @(posedge clk) begin
    if (rst) begin
      svf <= 1'b1;
      nvf <= 1'b1;
      caf <= 1'b0;
      wef <= 1'b0;
      wcf <= 1'b0;
    end else begin
      if (apply && (held.addr == OFS_STAT)) begin
        if (held.data[ST_SVF]) svf <= 1'b0;
        if (held.data[ST_NVF]) nvf <= 1'b0;
        if (held.data[ST_CAF]) caf <= 1'b0;
        if (held.data[ST_WEF]) wef <= 1'b0;
      end
      if (reject)    wef <= 1'b1;
      if (alarm_hit) caf <= 1'b1;
      if (rd_stat)   wcf <= 1'b0;
      if (apply)     wcf <= 1'b1;
    end
  end

  // interrupt enable: direct bus-speed path
  always_ff @(posedge clk) begin
    if (rst)                               ien <= '0;
    else if (bus_wr && bus_addr == OFS_IEN) ien <= bus_wdata & IEN_MASK;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |(status & ien);
      if (bus_rd) begin
        unique case (bus_addr)
          OFS_SEC:      bus_rdata <= sec;
          OFS_FRAC:     bus_rdata <= DATA_W'(frac);
          OFS_ALM_SEC:  bus_rdata <= alm_sec;
          OFS_ALM_FRAC: bus_rdata <= DATA_W'(alm_frac);
          OFS_CTRL:     bus_rdata <= ctrl;
          OFS_STAT:     bus_rdata <= status;
          OFS_IEN:      bus_rdata <= ien;
          default:      bus_rdata <= '0;
        endcase
      end
    end
  end

  // R5: completion of a staged write is always flagged
  a_r5_done_flag: assert property (@(posedge clk) disable iff (rst)
    $fell(pend) |-> wcf);

  // R7: enable writes land in the next cycle
  a_r7_ien_now: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == OFS_IEN) |=> (ien == ($past(bus_wdata) & IEN_MASK)));

  // R9: a match while valid raises the alarm flag
  a_r9_alarm_set: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |=> caf);

  // R10: nothing enabled means no interrupt
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    (ien == '0) |=> !irq);
endmodule

// File: tb/sim_rtc_lp_counter.sv
module sim_rtc_lp_counter;
  localparam int FRAC_W = 4;
  localparam logic [4:0] A_SEC = 5'h00, A_FRAC = 5'h04, A_ASEC = 5'h08,
                         A_AFRAC = 5'h0C, A_CTRL = 5'h10, A_STAT = 5'h14, A_IEN = 5'h18;

  logic        clk = 1'b0, lp_clk = 1'b0, rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0, irq;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  int checks = 0, fails = 0;

  always #5  clk = ~clk;
  always #40 lp_clk = ~lp_clk;

  rtc_lp_counter #(.FRAC_W(FRAC_W), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst(rst), .lp_clk(lp_clk), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq));

  function automatic logic [31:0] ien_model(logic [31:0] v);
    return v & 32'h0000_0390;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_range(string req, logic [31:0] act, logic [31:0] lo, logic [31:0] hi);
    checks++;
    if (act < lo || act > hi) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  // all tasks start and end on a falling clock edge
  task automatic wr(logic [4:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(output logic [31:0] st);
    st = '0;
    for (int i = 0; i < 64; i++) begin
      rd(A_STAT, st);
      if (!st[10]) break;
    end
  endtask

  task automatic wr_wait(logic [4:0] a, logic [31:0] d);
    logic [31:0] st;
    wr(a, d);
    idle(st);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] v, s0, s1;
    void'($urandom(32'd7031));
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);  chk("R1 status", v, 32'h203);
    rd(A_SEC, v);   chk("R1 seconds", v, 0);
    rd(A_FRAC, v);  chk("R1 fraction", v, 0);
    rd(A_ASEC, v);  chk("R1 alarm", v, 32'hFFFF_FFFF);
    rd(A_CTRL, v);  chk("R1 control", v, 0);
    rd(A_IEN, v);   chk("R1 enable", v, 0);
    chk("R1 irq", irq, 0);

    // R7 / R10 immediate enables, ready flag interrupt
    wr(A_IEN, 32'hFFFF_FFFF);
    rd(A_IEN, v);   chk("R7 enable mask", v, 32'h390);
    repeat (2) @(negedge clk);
    chk("R10 ready irq", irq, 1);
    wr(A_IEN, 0);
    repeat (2) @(negedge clk);
    chk("R10 irq off", irq, 0);
    for (int i = 0; i < 8; i++) begin
      logic [31:0] r;
      r = $urandom;
      wr(A_IEN, r);
      rd(A_IEN, v);  chk("R7 random enable", v, ien_model(r));
    end
    rd(A_STAT, v);   chk("R7 no complete flag", v[8], 0);
    wr(A_IEN, 0);

    // R8 / R5 clear security flag only, complete flag read-clear
    wr(A_STAT, 32'h1);
    idle(v);         chk("R8 clear one flag", v, 32'h302);
    rd(A_STAT, v);   chk("R5 cleared by read", v, 32'h202);

    // R4 busy visible right after a staged write
    wr(A_CTRL, 32'h8);
    rd(A_STAT, v);   chk("R4 busy/ready", v[10:9], 2'b10);
    idle(v);
    repeat (300) @(negedge clk);
    rd(A_SEC, v);    chk("R3 held while not valid", v, 0);
    wr_wait(A_STAT, 32'h2);
    repeat (300) @(negedge clk);
    rd(A_FRAC, v);   chk("R3 held until seconds written", v, 0);

    // R6 back-to-back write refused
    wr(A_FRAC, 0);
    wr(A_SEC, 32'd5);
    idle(v);         chk("R6 error flag", v, 32'h380);
    repeat (200) @(negedge clk);
    rd(A_SEC, v);    chk("R6 write dropped", v, 0);
    wr_wait(A_STAT, 32'h80);
    rd(A_STAT, v);   chk("R8 error cleared", v[7], 0);

    // R4 random loads while stopped
    wr_wait(A_CTRL, 0);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] r, f;
      r = $urandom; f = $urandom;
      wr_wait(A_SEC, r);
      wr_wait(A_FRAC, f);
      wr_wait(A_AFRAC, f);
      rd(A_SEC, v);   chk("R4 seconds load", v, r);
      rd(A_FRAC, v);  chk("R4 fraction load", v, f & 32'hF);
      rd(A_AFRAC, v); chk("R4 alarm fraction", v, f & 32'hF);
    end

    // R2 carry from fraction into seconds
    wr_wait(A_FRAC, 32'hF);
    wr_wait(A_SEC, 32'd200);
    wr_wait(A_CTRL, 32'h8);
    repeat (32) @(negedge clk);
    rd(A_SEC, v);    chk("R2 carry", v, 32'd201);
    rd(A_FRAC, v);   chk_range("R2 fraction after wrap", v, 1, 7);

    // R2 rate: 16 slow edges per second
    rd(A_SEC, s0);
    repeat (512) @(negedge clk);
    rd(A_SEC, s1);
    chk_range("R2 rate", s1 - s0, 3, 5);

    // R3 stop freezes the count
    wr_wait(A_CTRL, 0);
    rd(A_FRAC, s0);
    repeat (200) @(negedge clk);
    rd(A_FRAC, s1);  chk("R3 stopped", s1, s0);

    // R9 / R10 alarm
    wr_wait(A_FRAC, 0);
    wr_wait(A_SEC, 32'd300);
    wr_wait(A_ASEC, 32'd301);
    wr(A_IEN, 32'h10);
    wr(A_CTRL, 32'h8);
    idle(v);         chk("R9 no early alarm", v, 32'h300);
    repeat (300) @(negedge clk);
    rd(A_STAT, v);   chk("R9 alarm flag", v[4], 1);
    chk("R10 alarm irq", irq, 1);
    wr(A_IEN, 0);
    repeat (2) @(negedge clk);
    chk("R10 gated", irq, 0);
    wr_wait(A_ASEC, 32'hFFFF_FFFF);
    wr_wait(A_STAT, 32'h10);
    rd(A_STAT, v);   chk("R8 alarm cleared", v[4], 0);

    summary();
  end
endmodule